// File: doc/BRIEF.md
# Two-Wire Debug Bus Host Transaction Engine

This block is the host side of a two-wire serial debug link. It drives the bit clock and the shared bidirectional data line, and runs one target register access for each start request. A request names the register space (debug port or access port), the direction, two address bits and, for writes, a 32-bit word. The engine sends the 8-bit request header, hands the line to the target for turnaround and the 3-bit acknowledge, and then moves the data word in the direction the request asks for. It finishes with a stretch of host-driven low cycles and pulses `done_o` together with the acknowledge, the read word and a read parity flag.

The bit clock is made from the system clock by a divider whose half-period is set by an input and latched at the start of each transaction. The host changes the data line only while the bit clock is low and samples target bits on its rising edge. The data line is exposed as an output value, an output enable and an input, so an external pad can form the tri-state.

Top module: `swd_host_engine`

## Requirements
- R1: The header is sent in the first 8 bit slots with the enable high throughout. The slot order is: start=1, port select (1=access port), read flag (1=read), addr_i[0], addr_i[1], header parity, stop=0, park=1.
- R2: The header parity slot is 1 when port select, read flag, addr_i[0] and addr_i[1] hold an odd number of ones, else 0.
- R3: The enable is low for slot 8, which is the turnaround after the header, and for the three acknowledge slots. It is also low for the one-slot turnaround that returns the line to the host.
- R4: The acknowledge is taken from slots 9 to 11, least significant bit first, and reported on ack_o. The value 3'b001 means OK; 3'b010 (wait) and 3'b100 (fault) are examples of non-OK values.
- R5: A read with an OK acknowledge takes 32 target bits from slots 12 to 43, least significant bit first, and presents them on rdata_o at done.
- R6: On a read with an OK acknowledge, parity_err_o is 1 at done when the target parity bit in slot 44 differs from the odd-count parity of the 32 received bits. In every other case parity_err_o is 0.
- R7: A write with an OK acknowledge drives wdata_i, least significant bit first, in slots 13 to 44 with the enable high, then its odd-count parity in slot 45.
- R8: Any acknowledge other than 3'b001 skips the data phase. The transaction then takes 21 slots, against 54 slots for a transaction with an OK acknowledge.
- R9: The last 8 slots of each transaction are driven low by the host with the enable high.
- R10: Each bit-clock phase lasts half_period_i+1 system clocks. The data output never changes while the bit clock is high. The bit clock stays low when no transaction is running.
- R11: done_o is a single-cycle pulse. A start request made while busy_o is high is ignored.
- R12: After reset the engine is idle: bit clock low, busy_o and done_o low, and the line driven low with the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_period_i | input | 8 | Bit-clock half period minus one, in system clocks |
| start_i | input | 1 | Start a transaction (taken only when idle) |
| ap_ndp_i | input | 1 | Register space: 1 access port, 0 debug port |
| rnw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 2 | Register address bits [3:2] |
| wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 32 | Last read word |
| ack_o | output | 3 | Received acknowledge |
| parity_err_o | output | 1 | Read parity mismatch |
| swclk_o | output | 1 | Debug bit clock |
| swdio_o | output | 1 | Data line value when driven |
| swdio_oe_o | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line as seen at the pad |

## Verification
The hardest case to reach is a corrupt read parity bit that arrives together with otherwise valid data. The other hard case is a start request issued in the middle of a running transfer. The bench acts as the target, clocked by the engine's own bit clock. It can return any acknowledge value and any data word, and can flip the parity bit on demand. In one write, the bench pulses start with different fields partway through and then confirms that the captured bus traffic still matches the original request.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_TRN1, S_ACK, S_TRN2,
    S_RDATA, S_RPAR, S_WDATA, S_WPAR, S_TAIL
  } seq_state_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  // bit 0 goes on the wire first
  function automatic logic [7:0] build_hdr(logic ap, logic rnw, logic [1:0] a);
    return {1'b1, 1'b0, (ap ^ rnw ^ a[0] ^ a[1]), a[1], a[0], rnw, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             swclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_q;
  logic             clk_q;
  logic             tick;

  assign tick    = run_i && (cnt_q == half_q);
  assign rise_o  = tick && !clk_q;
  assign fall_o  = tick && clk_q;
  assign swclk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= '0;
      clk_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      half_q <= half_i;  // latched while idle, frozen during a transfer
    end else if (tick) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_clk_low_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !swclk_o);

  p_half_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(half_q));

endmodule

// File: rtl/swd_rx.sv
module swd_rx #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              ack_en_i,
  input  logic              data_en_i,
  input  logic              par_en_i,
  input  logic              din_i,
  output logic [2:0]        ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o
);

  logic [2:0]        ack_q;
  logic [DATA_W-1:0] data_q;
  logic              par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= '0;
      data_q <= '0;
      par_q  <= 1'b0;
    end else if (clr_i) begin
      ack_q  <= '0;
      data_q <= '0;
      par_q  <= 1'b0;
    end else if (rise_i) begin
      if (ack_en_i)  ack_q  <= {din_i, ack_q[2:1]};
      if (data_en_i) data_q <= {din_i, data_q[DATA_W-1:1]};
      if (par_en_i)  par_q  <= din_i;
    end
  end

  assign ack_o  = ack_q;
  assign data_o = data_q;
  assign perr_o = (^data_q) ^ par_q;

  p_one_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_en_i, data_en_i, par_en_i}));

endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_host_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAIL_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ap_ndp_i,
  input  logic              rnw_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fall_i,
  input  logic [2:0]        rx_ack_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  output logic              rx_clr_o,
  output logic              ack_en_o,
  output logic              data_en_o,
  output logic              par_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [2:0]        ack_o,
  output logic              perr_o,
  output logic              dout_o,
  output logic              oe_o
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(2);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_N - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [7:0]        hdr_q;
  logic [DATA_W-1:0] wsh_q;
  logic              wpar_q;
  logic              rnw_q;
  logic              dout_q, oe_q, busy_q, done_q, perr_q;
  logic [2:0]        ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic              accept;

  assign accept    = (state_q == S_IDLE) && start_i;
  assign rx_clr_o  = accept;
  assign ack_en_o  = (state_q == S_ACK);
  assign data_en_o = (state_q == S_RDATA);
  assign par_en_o  = (state_q == S_RPAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      bitcnt_q <= '0;
      hdr_q    <= '0;
      wsh_q    <= '0;
      wpar_q   <= 1'b0;
      rnw_q    <= 1'b0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      perr_q   <= 1'b0;
      ack_q    <= '0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == S_IDLE) begin
        if (start_i) begin
          hdr_q    <= build_hdr(ap_ndp_i, rnw_i, addr_i);
          dout_q   <= 1'b1;
          oe_q     <= 1'b1;
          wsh_q    <= wdata_i;
          wpar_q   <= ^wdata_i;
          rnw_q    <= rnw_i;
          busy_q   <= 1'b1;
          ack_q    <= '0;
          perr_q   <= 1'b0;
          bitcnt_q <= '0;
          state_q  <= S_HDR;
        end
      end else if (fall_i) begin
        case (state_q)
          S_HDR: begin
            if (bitcnt_q == HDR_LAST) begin
              state_q  <= S_TRN1;
              oe_q     <= 1'b0;
              bitcnt_q <= '0;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
              dout_q   <= hdr_q[1];
              hdr_q    <= {1'b0, hdr_q[7:1]};
            end
          end
          S_TRN1: begin
            state_q  <= S_ACK;
            bitcnt_q <= '0;
          end
          S_ACK: begin
            if (bitcnt_q == ACK_LAST) begin
              ack_q    <= rx_ack_i;
              bitcnt_q <= '0;
              state_q  <= (rx_ack_i == ACK_OK && rnw_q) ? S_RDATA : S_TRN2;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
          S_RDATA: begin
            if (bitcnt_q == DATA_LAST) begin
              state_q  <= S_RPAR;
              bitcnt_q <= '0;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
          S_RPAR: begin
            rdata_q <= rx_data_i;
            perr_q  <= rx_perr_i;
            state_q <= S_TRN2;
          end
          S_TRN2: begin
            oe_q     <= 1'b1;
            bitcnt_q <= '0;
            if (!rnw_q && ack_q == ACK_OK) begin
              state_q <= S_WDATA;
              dout_q  <= wsh_q[0];
            end else begin
              state_q <= S_TAIL;
              dout_q  <= 1'b0;
            end
          end
          S_WDATA: begin
            if (bitcnt_q == DATA_LAST) begin
              state_q  <= S_WPAR;
              dout_q   <= wpar_q;
              bitcnt_q <= '0;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
              dout_q   <= wsh_q[1];
              wsh_q    <= {1'b0, wsh_q[DATA_W-1:1]};
            end
          end
          S_WPAR: begin
            state_q  <= S_TAIL;
            dout_q   <= 1'b0;
            bitcnt_q <= '0;
          end
          S_TAIL: begin
            if (bitcnt_q == TAIL_LAST) begin
              state_q <= S_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign ack_o   = ack_q;
  assign perr_o  = perr_q;
  assign dout_o  = dout_q;
  assign oe_o    = oe_q;

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(rnw_q));

  p_trn_float_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TRN1 || state_q == S_TRN2 || state_q == S_ACK) |-> !oe_q);

  p_park_driven_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HDR && bitcnt_q == HDR_LAST) |-> (oe_q && dout_q));

  p_nonok_skip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ACK && fall_i && bitcnt_q == ACK_LAST && rx_ack_i != ACK_OK)
      |=> state_q == S_TRN2);

  p_perr_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_q |-> rnw_q);

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int TAIL_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_period_i,
  input  logic              start_i,
  input  logic              ap_ndp_i,
  input  logic              rnw_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [2:0]        ack_o,
  output logic              parity_err_o,
  output logic              swclk_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  input  logic              swdio_i
);

  logic              rise, fall;
  logic              rx_clr, ack_en, data_en, par_en;
  logic [2:0]        rx_ack;
  logic [DATA_W-1:0] rx_data;
  logic              rx_perr;

  swd_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy_o),
    .half_i  (half_period_i),
    .swclk_o (swclk_o),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  swd_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rx_clr),
    .rise_i    (rise),
    .ack_en_i  (ack_en),
    .data_en_i (data_en),
    .par_en_i  (par_en),
    .din_i     (swdio_i),
    .ack_o     (rx_ack),
    .data_o    (rx_data),
    .perr_o    (rx_perr)
  );

  swd_seq #(.DATA_W(DATA_W), .TAIL_N(TAIL_N)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ap_ndp_i  (ap_ndp_i),
    .rnw_i     (rnw_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .fall_i    (fall),
    .rx_ack_i  (rx_ack),
    .rx_data_i (rx_data),
    .rx_perr_i (rx_perr),
    .rx_clr_o  (rx_clr),
    .ack_en_o  (ack_en),
    .data_en_o (data_en),
    .par_en_o  (par_en),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o),
    .ack_o     (ack_o),
    .perr_o    (parity_err_o),
    .dout_o    (swdio_o),
    .oe_o      (swdio_oe_o)
  );

  p_dio_hold_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swclk_o && $past(swclk_o)) |-> ($stable(swdio_o) && $stable(swdio_oe_o)));

  p_done_idle_clk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !swclk_o);

endmodule

// File: tb/swd_host_engine_bench.sv
module swd_host_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_period;
  logic        start, ap_ndp, rnw;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic        busy, done, perr, swclk, swdio_o, swdio_oe;
  logic [31:0] rdata;
  logic [2:0]  ack;
  logic        swdio_i = 1'b0;

  always #5 clk = ~clk;

  swd_host_engine u_swd_host_engine (
    .clk_i(clk), .rst_ni(rst_n), .half_period_i(half_period), .start_i(start),
    .ap_ndp_i(ap_ndp), .rnw_i(rnw), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .ack_o(ack),
    .parity_err_o(perr), .swclk_o(swclk), .swdio_o(swdio_o),
    .swdio_oe_o(swdio_oe), .swdio_i(swdio_i)
  );

  typedef struct {
    logic [7:0]  hdr;
    logic        rnw;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        perr;
    logic [31:0] wdata;
    int          slots;
    int          half;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;

  // target model state
  logic [2:0]  tgt_ack;
  logic [31:0] tgt_data;
  logic        tgt_bad, tgt_rd;
  int          rise_cnt = 0;
  logic [63:0] cap_d, cap_oe;
  time         t0, t1;
  logic        done_seen = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge swclk) begin
    if (rise_cnt < 64) begin
      cap_d[rise_cnt]  = swdio_o;
      cap_oe[rise_cnt] = swdio_oe;
    end
    if (rise_cnt == 0) t0 = $time;
    if (rise_cnt == 1) t1 = $time;
    rise_cnt++;
  end

  always @(negedge swclk) begin
    if (rise_cnt >= 9 && rise_cnt <= 11)
      swdio_i = tgt_ack[rise_cnt-9];
    else if (tgt_rd && rise_cnt >= 12 && rise_cnt <= 43)
      swdio_i = tgt_data[rise_cnt-12];
    else if (tgt_rd && rise_cnt == 44)
      swdio_i = (^tgt_data) ^ tgt_bad;
    else
      swdio_i = 1'b0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (done_seen) begin
      chk("R11 done single pulse", done, 0);
      done_seen = 1'b0;
    end
    if (done && exp_q.size() > 0) begin
      exp_t e;
      int   tr;
      logic ok;
      e  = exp_q.pop_front();
      ok = (e.ack == 3'b001);
      done_seen = 1'b1;
      chk("R1 header bits", cap_d[7:0], e.hdr);
      chk("R1 header driven", cap_oe[7:0], 8'hFF);
      chk("R2 header parity", cap_d[5], ^e.hdr[4:1]);
      chk("R3 first turnaround released", cap_oe[8], 0);
      chk("R3 ack slots released", cap_oe[11:9], 0);
      tr = (e.rnw && ok) ? 45 : 12;
      chk("R3 second turnaround released", cap_oe[tr], 0);
      chk("R4 ack value", ack, e.ack);
      chk("R8 slot count", rise_cnt, e.slots);
      chk("R6 parity flag", perr, e.perr);
      if (e.rnw && ok) begin
        chk("R5 read data", rdata, e.rdata);
        chk("R5 data slots released", cap_oe[44:12], 0);
      end
      if (!e.rnw && ok) begin
        chk("R7 write data", cap_d[44:13], e.wdata);
        chk("R7 write parity", cap_d[45], ^e.wdata);
        chk("R7 write driven", cap_oe[45:13], {33{1'b1}});
      end
      for (int s = e.slots - 8; s < e.slots; s++) begin
        chk("R9 tail low", cap_d[s], 0);
        chk("R9 tail driven", cap_oe[s], 1);
      end
      chk("R10 bit period", 64'(t1 - t0), 64'(2 * (e.half + 1) * 10));
    end
  end

  task automatic run_txn(input logic a_ap, input logic a_rnw, input logic [1:0] a_addr,
                         input logic [31:0] a_wd, input logic [2:0] a_ack,
                         input logic [31:0] a_rd, input logic a_bad,
                         input int a_half, input bit glitch);
    exp_t e;
    tgt_ack  = a_ack;
    tgt_data = a_rd;
    tgt_bad  = a_bad;
    tgt_rd   = a_rnw && (a_ack == 3'b001);
    half_period = 8'(a_half);
    ap_ndp = a_ap; rnw = a_rnw; addr = a_addr; wdata = a_wd;
    e.hdr   = {1'b1, 1'b0, (a_ap ^ a_rnw ^ a_addr[0] ^ a_addr[1]), a_addr[1], a_addr[0], a_rnw, a_ap, 1'b1};
    e.rnw   = a_rnw;
    e.ack   = a_ack;
    e.rdata = a_rd;
    e.perr  = a_rnw && (a_ack == 3'b001) && a_bad;
    e.wdata = a_wd;
    e.slots = (a_ack == 3'b001) ? 54 : 21;
    e.half  = a_half;
    exp_q.push_back(e);
    rise_cnt = 0;
    cap_d = '0; cap_oe = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (glitch) begin
      repeat (60) @(negedge clk);
      start = 1'b1; rnw = ~a_rnw; ap_ndp = ~a_ap; addr = ~a_addr; wdata = ~a_wd;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    start = 0; ap_ndp = 0; rnw = 0; addr = 0; wdata = 0; half_period = 1;
    tgt_ack = 0; tgt_data = 0; tgt_bad = 0; tgt_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset clock low", swclk, 0);
    chk("R12 reset idle", {busy, done}, 0);
    chk("R12 reset line low", swdio_o, 0);
    chk("R12 reset line driven", swdio_oe, 1);
    // R5 read, debug port, OK
    run_txn(0, 1, 2'b00, 32'h0, 3'b001, 32'h2BA01477, 0, 1, 0);
    // R6 corrupt parity on access port read
    run_txn(1, 1, 2'b11, 32'h0, 3'b001, 32'hFFFFFFFF, 1, 1, 0);
    // R7 write, fastest clock
    run_txn(0, 0, 2'b10, 32'h000000F0, 3'b001, 32'h0, 0, 0, 0);
    // R8 wait on write
    run_txn(1, 0, 2'b01, 32'h80000001, 3'b010, 32'h0, 0, 2, 0);
    // R8 fault on read
    run_txn(1, 1, 2'b10, 32'h0, 3'b100, 32'h12345678, 0, 1, 0);
    // R4 invalid ack treated as non-OK
    run_txn(0, 1, 2'b01, 32'h0, 3'b111, 32'h0, 0, 3, 0);
    // R11 start ignored while busy
    run_txn(0, 0, 2'b11, 32'hDEADBEEF, 3'b001, 32'h0, 0, 2, 1);
    // R6 parity mismatch with zero data
    run_txn(1, 1, 2'b00, 32'h0, 3'b001, 32'h00000000, 1, 1, 0);
    // R6 clean read after an error
    run_txn(1, 1, 2'b01, 32'h0, 3'b001, 32'hA5A5A5A4, 0, 1, 0);
    chk("R12 idle line low after transfer", swdio_o, 0);
    chk("R10 clock low when idle", swclk, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule